// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM array alive. After reset it holds the RAS, CAS and WE strobes inactive for a fixed start-up delay. It then runs a back-to-back burst of CAS-before-RAS wake-up cycles by itself. Once those finish it raises `init_done`, and from that point a periodic timer adds refresh credits. Each credit is offered to the memory controller as a refresh request.

The request/grant pair works as a valid/ready handshake. `ref_req` is the valid and `ref_gnt` is the ready. A handshake happens on a rising edge where both are high. `ref_req` never drops without a handshake; it only drops when the sequencer leaves idle. The controller may hold off `ref_gnt` for as long as it likes: unserved credits queue up, to a fixed limit. After a handshake the sequencer owns the strobes and `own_bus` is high until the cycle's precharge ends. The controller muxes the pins on `own_bus` and must not serve host traffic while `init_done` is low.

A refresh is CAS-before-RAS by default. If `ro_mode` is high at the handshake edge, the sequencer instead runs a RAS-only cycle that puts an internal row counter on `addr`. The row counter advances after each such cycle.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, `ras_n`, `cas_n` and `we_n` are 1, `addr` is 0, `ref_req` and `init_done` are 0, and `own_bus` is 1.
- R2: No strobe goes low until STARTUP_CYC clock edges after reset release (default 20000, i.e. 200 us at 100 MHz). The first wake-up cycle drives CAS low right after edge STARTUP_CYC+1.
- R3: The block runs exactly INIT_CYCLES (default 8) CAS-before-RAS wake-up cycles, each followed by one idle cycle. `init_done` rises after the edge that ends the last precharge, which is edge STARTUP_CYC + INIT_CYCLES*(ACT+1), where ACT = CSR_CYC + RAS_CYC + PRE. `ref_req` stays 0 before that.
- R4: A CAS-before-RAS cycle has three phases. First CAS alone is low for CSR_CYC cycles. Then RAS is low for RAS_CYC cycles, with CAS still low for the first CHR_CYC of them. Last, both are high for PRE cycles. PRE is RP_CYC, raised if needed so that CSR_CYC+RAS_CYC+PRE reaches RC_CYC (default 1/6/4, 11 cycles in all).
- R5: `we_n` is 1 in every cycle, so no strobe pattern can enter the array's test mode.
- R6: After `init_done`, one credit is added every REFI_CYC edges (default 1562, under 15.625 us). The first is added at edge REFI_CYC after `init_done` rises.
- R7: `ref_req` is 1 exactly when credits are nonzero, `init_done` is 1 and the sequencer is idle. A handshake starts the cycle on the next edge and removes one credit.
- R8: The credit count saturates at MAX_CREDIT (default 8). An unserved credit stays until it is granted. A tick and a handshake on the same edge leave the count unchanged.
- R9: A RAS-only cycle is chosen when `ro_mode` is 1 at the handshake edge. It first puts the row on `addr` for one cycle with both strobes high. It then holds RAS low for RAS_CYC cycles with CAS high and the row kept on `addr`, and then precharges. The row starts at 0 after reset and steps by one modulo 2^ROW_W after each such cycle. `addr` is 0 at all other times.
- R10: `ref_gnt` while `ref_req` is 0 has no effect on the strobes, `own_bus` or the credits.
- R11: `own_bus` is 1 from reset until `init_done`, and from the first cycle of a granted refresh through the end of its precharge. It is 0 when the block is idle after initialisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz nominal |
| rst_n | input | 1 | Synchronous reset, active low |
| ro_mode | input | 1 | Selects a RAS-only refresh when sampled high at a handshake |
| ref_gnt | input | 1 | Grant (ready) from the memory controller |
| ref_req | output | 1 | Refresh request (valid) to the memory controller |
| init_done | output | 1 | High once the wake-up burst has completed |
| own_bus | output | 1 | Sequencer is driving the DRAM strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| addr | output | ROW_W | Row address for RAS-only refresh |

## Verification
The hardest state to reach is a full credit store. A handshake and a timer tick must land on the same edge while the count is at its ceiling, so that saturation and the same-edge rule act together. The stimulus withholds the grant for more than MAX_CREDIT intervals so the count pins at the limit. It then grants once and checks that a request is still pending. Next it grants continuously, so the drain overlaps further ticks. Row wrap-around is reached by running more than 2^ROW_W RAS-only refreshes with a narrow row counter.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAS_LEAD,
    ST_RO_SETUP,
    ST_RAS_LOW,
    ST_PRECH
  } eng_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  // Precharge stretched so the whole strobe cycle meets the row cycle minimum
  function automatic int prech_len(input int rp, input int rc, input int csr, input int ras);
    if (rc > csr + ras + rp) return rc - csr - ras;
    return rp;
  endfunction

endpackage

// File: rtl/dram_rfsh_timer.sv
module dram_rfsh_timer #(
  parameter int STARTUP_CYC = 20000,
  parameter int REFI_CYC    = 1562,
  parameter int INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_cycle_end,
  output logic startup_ok,
  output logic init_done,
  output logic tick
);

  localparam int ST_W = $clog2(STARTUP_CYC + 1);
  localparam int IV_W = (REFI_CYC > 1) ? $clog2(REFI_CYC) : 1;
  localparam int IN_W = $clog2(INIT_CYCLES + 1);

  logic [ST_W-1:0] st_cnt_q;
  logic [IV_W-1:0] iv_cnt_q;
  logic [IN_W-1:0] init_left_q;

  assign startup_ok = (st_cnt_q == ST_W'(STARTUP_CYC));
  assign init_done  = (init_left_q == '0);
  assign tick       = init_done && (iv_cnt_q == IV_W'(REFI_CYC - 1));

  // Start-up delay counter, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_cnt_q <= '0;
    end else if (!startup_ok) begin
      st_cnt_q <= st_cnt_q + 1'b1;
    end
  end

  // Remaining wake-up cycles
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_left_q <= IN_W'(INIT_CYCLES);
    end else if (init_cycle_end && !init_done) begin
      init_left_q <= init_left_q - 1'b1;
    end
  end

  // Refresh interval counter, runs only after wake-up
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iv_cnt_q <= '0;
    end else if (init_done) begin
      if (tick) iv_cnt_q <= '0;
      else      iv_cnt_q <= iv_cnt_q + 1'b1;
    end
  end

  // R3: a wake-up cycle can only finish while the burst is still running
  p_init_end_in_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    init_cycle_end |-> !init_done);

  // R6: ticks never come before the start-up delay has elapsed
  p_tick_after_startup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> startup_ok);

endmodule

// File: rtl/dram_rfsh_credit.sv
module dram_rfsh_credit #(
  parameter int MAX_CREDIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  output logic has_credit
);

  localparam int CR_W = $clog2(MAX_CREDIT + 1);
  localparam logic [CR_W-1:0] CR_MAX = CR_W'(MAX_CREDIT);

  logic [CR_W-1:0] cr_q;

  assign has_credit = (cr_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_q <= '0;
    end else begin
      unique case ({tick, take})
        2'b10:   if (cr_q != CR_MAX) cr_q <= cr_q + 1'b1;
        2'b01:   cr_q <= cr_q - 1'b1;
        default: cr_q <= cr_q;
      endcase
    end
  end

  // R8: a full store stays full when a tick arrives without a grant
  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_q == CR_MAX && tick && !take) |=> (cr_q == CR_MAX));

  // R7: a grant is only accepted while a credit is pending
  p_take_needs_credit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> has_credit);

  // R8: count never exceeds its ceiling
  p_credit_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cr_q <= CR_MAX);

endmodule

// File: rtl/dram_rfsh_engine.sv
module dram_rfsh_engine
  import dram_rfsh_pkg::*;
#(
  parameter int ROW_W   = 12,
  parameter int CSR_CYC = 1,
  parameter int CHR_CYC = 1,
  parameter int RAS_CYC = 6,
  parameter int PRE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_init,
  input  logic             start_ref,
  input  logic             ro_sel,
  output logic             idle,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] addr,
  output logic             init_cycle_end
);

  localparam int PMAX    = max3(CSR_CYC, RAS_CYC, PRE_CYC);
  localparam int PC_W    = $clog2(PMAX + 1);
  localparam int CAS_REL = RAS_CYC - CHR_CYC;

  eng_state_t       state_q;
  logic [PC_W-1:0]  pcnt_q;
  logic             ro_q;
  logic             init_q;
  logic [ROW_W-1:0] row_q;
  logic             phase_end;
  logic             cas_hold;

  assign phase_end = (pcnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pcnt_q  <= '0;
      ro_q    <= 1'b0;
      init_q  <= 1'b0;
      row_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_init) begin
            state_q <= ST_CAS_LEAD;
            pcnt_q  <= PC_W'(CSR_CYC - 1);
            ro_q    <= 1'b0;
            init_q  <= 1'b1;
          end else if (start_ref) begin
            ro_q   <= ro_sel;
            init_q <= 1'b0;
            if (ro_sel) begin
              state_q <= ST_RO_SETUP;
              pcnt_q  <= '0;
            end else begin
              state_q <= ST_CAS_LEAD;
              pcnt_q  <= PC_W'(CSR_CYC - 1);
            end
          end
        end
        ST_CAS_LEAD, ST_RO_SETUP: begin
          if (phase_end) begin
            state_q <= ST_RAS_LOW;
            pcnt_q  <= PC_W'(RAS_CYC - 1);
          end else begin
            pcnt_q <= pcnt_q - 1'b1;
          end
        end
        ST_RAS_LOW: begin
          if (phase_end) begin
            state_q <= ST_PRECH;
            pcnt_q  <= PC_W'(PRE_CYC - 1);
            if (ro_q) row_q <= row_q + 1'b1;
          end else begin
            pcnt_q <= pcnt_q - 1'b1;
          end
        end
        ST_PRECH: begin
          if (phase_end) state_q <= ST_IDLE;
          else           pcnt_q  <= pcnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // CAS hold after RAS falls exists only when a hold time is configured
  generate
    if (CHR_CYC > 0) begin : g_cas_hold
      assign cas_hold = (state_q == ST_RAS_LOW) && !ro_q && (pcnt_q >= PC_W'(CAS_REL));
    end else begin : g_no_cas_hold
      assign cas_hold = 1'b0;
    end
  endgenerate

  assign idle           = (state_q == ST_IDLE);
  assign ras_n          = (state_q != ST_RAS_LOW);
  assign cas_n          = !((state_q == ST_CAS_LEAD) || cas_hold);
  assign addr           = (ro_q && (state_q == ST_RO_SETUP || state_q == ST_RAS_LOW)) ? row_q : '0;
  assign init_cycle_end = (state_q == ST_PRECH) && phase_end && init_q;

  // R4: in a CAS-before-RAS cycle, CAS was already low when RAS fell
  p_cas_before_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !ro_q) |-> !$past(cas_n));

  // R9: CAS stays high while RAS is low in a RAS-only cycle
  p_ro_cas_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && ro_q) |-> cas_n);

  // R4: precharge lasts more than one cycle
  p_precharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);

  // R9: row address is stable while RAS is low
  p_row_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && $past(!ras_n)) |-> $stable(addr));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int STARTUP_CYC = 20000,
  parameter int REFI_CYC    = 1562,
  parameter int INIT_CYCLES = 8,
  parameter int MAX_CREDIT  = 8,
  parameter int CSR_CYC     = 1,
  parameter int CHR_CYC     = 1,
  parameter int RAS_CYC     = 6,
  parameter int RP_CYC      = 4,
  parameter int RC_CYC      = 11,
  parameter int ROW_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ro_mode,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             init_done,
  output logic             own_bus,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] addr
);

  localparam int PRE_CYC = prech_len(RP_CYC, RC_CYC, CSR_CYC, RAS_CYC);

  logic startup_ok;
  logic tick;
  logic has_credit;
  logic eng_idle;
  logic init_cycle_end;
  logic take;
  logic start_init;

  assign take       = ref_req && ref_gnt;
  assign start_init = startup_ok && !init_done;
  assign ref_req    = has_credit && init_done && eng_idle;
  assign own_bus    = !eng_idle || !init_done;
  assign we_n       = 1'b1;

  dram_rfsh_timer #(
    .STARTUP_CYC (STARTUP_CYC),
    .REFI_CYC    (REFI_CYC),
    .INIT_CYCLES (INIT_CYCLES)
  ) u_timer (
    .clk            (clk),
    .rst_n          (rst_n),
    .init_cycle_end (init_cycle_end),
    .startup_ok     (startup_ok),
    .init_done      (init_done),
    .tick           (tick)
  );

  dram_rfsh_credit #(
    .MAX_CREDIT (MAX_CREDIT)
  ) u_credit (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .take       (take),
    .has_credit (has_credit)
  );

  dram_rfsh_engine #(
    .ROW_W   (ROW_W),
    .CSR_CYC (CSR_CYC),
    .CHR_CYC (CHR_CYC),
    .RAS_CYC (RAS_CYC),
    .PRE_CYC (PRE_CYC)
  ) u_engine (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_init     (start_init),
    .start_ref      (take),
    .ro_sel         (ro_mode),
    .idle           (eng_idle),
    .ras_n          (ras_n),
    .cas_n          (cas_n),
    .addr           (addr),
    .init_cycle_end (init_cycle_end)
  );

  // R2: strobes stay inactive until the start-up delay has elapsed
  p_quiet_startup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !startup_ok |-> (ras_n && cas_n));

  // R7: a handshake removes the request on the next cycle
  p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt) |=> !ref_req);

  // R3: no request before the wake-up burst is complete
  p_no_req_in_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> init_done);

  // R11: the strobes only move while the sequencer owns the bus
  p_strobe_owned_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> own_bus);

endmodule

// File: tb/sim_dram_refresh_seq.sv
`timescale 1ns/1ps
module sim_dram_refresh_seq;

  localparam int CLK_PERIOD = 10;
  localparam int S     = 30;
  localparam int REFI  = 40;
  localparam int NINIT = 8;
  localparam int MAXC  = 8;
  localparam int CSR   = 1;
  localparam int CHR   = 1;
  localparam int RASC  = 6;
  localparam int RP    = 4;
  localparam int RC    = 11;
  localparam int ROWW  = 3;
  localparam int PRE   = (RC > CSR + RASC + RP) ? RC - CSR - RASC : RP;
  localparam int ACT   = CSR + RASC + PRE;

  logic clk, rst_n, ro_mode, ref_gnt;
  logic ref_req, init_done, own_bus, ras_n, cas_n, we_n;
  logic [ROWW-1:0] addr;

  dram_refresh_seq #(
    .STARTUP_CYC(S), .REFI_CYC(REFI), .INIT_CYCLES(NINIT), .MAX_CREDIT(MAXC),
    .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_CYC(RASC), .RP_CYC(RP), .RC_CYC(RC),
    .ROW_W(ROWW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ro_mode(ro_mode), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .init_done(init_done), .own_bus(own_bus),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  bit run_chk = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at t=%0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_st, m_left, m_credit, m_tcnt, m_row, cyc;
  int q_ras[$];
  int q_cas[$];
  int q_addr[$];
  int q_end[$];

  task automatic push(input int r, input int c, input int a, input int e);
    q_ras.push_back(r); q_cas.push_back(c); q_addr.push_back(a); q_end.push_back(e);
  endtask

  task automatic push_cbr(input int is_init);
    for (int i = 0; i < CSR; i++) push(1, 0, 0, 0);
    for (int i = 0; i < RASC; i++) push(0, (i < CHR) ? 0 : 1, 0, 0);
    for (int i = 0; i < PRE; i++) push(1, 1, 0, (i == PRE - 1) ? is_init : 0);
  endtask

  task automatic push_ro(input int r);
    push(1, 1, r, 0);
    for (int i = 0; i < RASC; i++) push(0, 1, r, 0);
    for (int i = 0; i < PRE; i++) push(1, 1, 0, 0);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_left = NINIT; m_credit = 0; m_tcnt = 0; m_row = 0; cyc = 0;
      q_ras.delete(); q_cas.delete(); q_addr.delete(); q_end.delete();
    end else begin
      bit busy, sok, done, req, tk, take;
      int e;
      cyc++;
      busy = (q_ras.size() > 0);
      sok  = (m_st == S);
      done = (m_left == 0);
      req  = (m_credit > 0) && done && !busy;
      take = req && (ref_gnt === 1'b1);
      tk   = done && (m_tcnt == REFI - 1);
      if (!sok) m_st++;
      if (done) m_tcnt = tk ? 0 : m_tcnt + 1;
      if (tk && !take) m_credit = (m_credit < MAXC) ? m_credit + 1 : MAXC;
      else if (take && !tk) m_credit--;
      if (busy) begin
        void'(q_ras.pop_front()); void'(q_cas.pop_front()); void'(q_addr.pop_front());
        e = q_end.pop_front();
        if (e != 0) m_left--;
      end
      if (!busy) begin
        if (!done && sok) push_cbr(1);
        else if (take) begin
          if (ro_mode === 1'b1) begin
            push_ro(m_row);
            m_row = (m_row + 1) % (1 << ROWW);
          end else begin
            push_cbr(0);
          end
        end
      end
    end
  end

  // ---------------- per-cycle compare and monitors ----------------
  int first_cas_cyc = -1;
  int done_cyc = -1;
  int init_falls = 0;
  int first_req_cyc = -1;
  int ro_seen = 0;
  logic prev_ras = 1'b1;

  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      int er, ec, ea;
      bit eo, eq, ed;
      er = (q_ras.size() > 0) ? q_ras[0] : 1;
      ec = (q_cas.size() > 0) ? q_cas[0] : 1;
      ea = (q_addr.size() > 0) ? q_addr[0] : 0;
      eo = (q_ras.size() > 0) || (m_left != 0);
      ed = (m_left == 0);
      eq = (m_credit > 0) && ed && (q_ras.size() == 0);
      chk(ras_n === er[0], "R4/R9", "ras_n", int'(ras_n), er);
      chk(cas_n === ec[0], "R4/R9", "cas_n", int'(cas_n), ec);
      chk(int'(addr) == ea, "R9", "addr", int'(addr), ea);
      chk(we_n === 1'b1, "R5", "we_n", int'(we_n), 1);
      chk(own_bus === eo, "R11", "own_bus", int'(own_bus), int'(eo));
      chk(ref_req === eq, "R7/R8", "ref_req", int'(ref_req), int'(eq));
      chk(init_done === ed, "R3", "init_done", int'(init_done), int'(ed));

      if (first_cas_cyc < 0 && cas_n === 1'b0) begin
        first_cas_cyc = cyc;
        chk(cyc == S + 1, "R2", "first CAS edge", cyc, S + 1);
      end
      if (prev_ras === 1'b1 && ras_n === 1'b0) begin
        if (init_done !== 1'b1) init_falls++;
        if (cas_n === 1'b1) begin
          chk(int'(addr) == ro_seen % (1 << ROWW), "R9", "RAS-only row", int'(addr), ro_seen % (1 << ROWW));
          ro_seen++;
        end
      end
      if (done_cyc < 0 && init_done === 1'b1) begin
        done_cyc = cyc;
        chk(cyc == S + NINIT * (ACT + 1), "R3", "init_done edge", cyc, S + NINIT * (ACT + 1));
        chk(init_falls == NINIT, "R3", "wake-up cycles", init_falls, NINIT);
      end
      if (done_cyc >= 0 && first_req_cyc < 0 && ref_req === 1'b1) begin
        first_req_cyc = cyc;
        chk(cyc == done_cyc + REFI, "R6", "first request edge", cyc, done_cyc + REFI);
      end
      prev_ras = ras_n;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0; ref_gnt = 1'b0; ro_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ras_n === 1'b1, "R1", "ras_n in reset", int'(ras_n), 1);
    chk(cas_n === 1'b1, "R1", "cas_n in reset", int'(cas_n), 1);
    chk(we_n === 1'b1, "R1", "we_n in reset", int'(we_n), 1);
    chk(addr == '0, "R1", "addr in reset", int'(addr), 0);
    chk(ref_req === 1'b0, "R1", "ref_req in reset", int'(ref_req), 0);
    chk(init_done === 1'b0, "R1", "init_done in reset", int'(init_done), 0);
    chk(own_bus === 1'b1, "R1", "own_bus in reset", int'(own_bus), 1);
    rst_n = 1'b1;
    run_chk = 1'b1;

    // wake-up burst with grant toggling (must be ignored)
    while (init_done !== 1'b1) begin
      @(negedge clk);
      ref_gnt = ~ref_gnt;
    end
    ref_gnt = 1'b0;

    // CAS-before-RAS refreshes granted at once
    repeat (REFI + 2) @(negedge clk);
    ref_gnt = 1'b1;
    repeat (4 * REFI) @(negedge clk);

    // withhold grants until the store saturates (R8)
    ref_gnt = 1'b0;
    repeat ((MAXC + 3) * REFI) @(negedge clk);
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    do @(negedge clk); while (own_bus === 1'b1);
    chk(ref_req === 1'b1, "R8", "request kept after one grant", int'(ref_req), 1);
    ref_gnt = 1'b1;
    repeat (12 * REFI) @(negedge clk);

    // RAS-only refreshes past the row wrap (R9)
    ro_mode = 1'b1;
    repeat (((1 << ROWW) + 3) * REFI) @(negedge clk);
    chk(ro_seen > (1 << ROWW), "R9", "RAS-only cycles seen", ro_seen, (1 << ROWW) + 1);
    ro_mode = 1'b0;

    // grant while no request (R10)
    do @(negedge clk); while (!(ref_req === 1'b0 && own_bus === 1'b0));
    @(negedge clk);
    chk(own_bus === 1'b0, "R10", "own_bus after idle grant", int'(own_bus), 0);
    chk(ras_n === 1'b1 && cas_n === 1'b1, "R10", "strobes after idle grant", int'({ras_n, cas_n}), 3);
    ref_gnt = 1'b0;
    repeat (2 * REFI) @(negedge clk);

    run_chk = 1'b0;
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule